// File: doc/BRIEF.md
# Three-Port Programmable Parallel I/O Peripheral

This block sits on a small processor bus and offers three 8-bit parallel ports, called A, B and C. The host reaches them through an 8-bit data bus. It uses an active-low chip select, active-low read and write strobes and a 2-bit address. Each port has an output latch, a per-bit output enable and an input sampled from its pins. The host decides at run time which ports drive and which ones listen. Port C is split into two nibbles, and each nibble takes its own direction.

The control address accepts two kinds of word, and bit 7 tells them apart. A configuration word sets the four directions and the two port modes, and it clears every output latch. A single-bit word sets or clears one port C latch bit and leaves everything else alone. When port A or port B is placed in the strobed handshake mode, the block reports which port C pins that handshake claims. It also stops driving those pins, so they are left to the handshake logic outside. The block does not implement the handshake itself or the bidirectional mode.

All bus activity is synchronous to `clk`. A write takes effect at each rising edge at which the chip select and the write strobe are both low. Read data is registered at each rising edge at which the chip select and the read strobe are both low. Between reads it holds its value.

Top module: `tpio_top`

## Requirements
- R1: Address 00 selects port A, 01 selects port B, 10 selects port C and 11 selects the control register. A write to a port address loads that port's whole output latch, which appears on its `*_out` pins after the write edge.
- R2: With `cs_n` high, neither a write nor a read has any effect: latches, directions and `rdata` keep their values.
- R3: Synchronous reset makes every port an input (all output enables 0), clears every output latch and `rdata`, and puts both ports in basic mode.
- R4: A control write with bit 7 = 1 is a configuration word. Bits 6:5 set the port A mode (01 = handshake, any other value = basic). Bit 4 sets the port A direction (1 = input). Bit 3 sets the upper C nibble direction (1 = input). Bit 2 sets the port B mode (1 = handshake). Bit 1 sets the port B direction (1 = input). Bit 0 sets the lower C nibble direction (1 = input).
- R5: Writing a configuration word clears the port A, B and C output latches to zero.
- R6: A control write with bit 7 = 0 is a single-bit word. Bits 3:1 give the port C bit index and bit 0 the new value. Exactly that latch bit changes, and no direction changes.
- R7: The upper C nibble (bits 7:4) and the lower C nibble (bits 3:0) each take their own direction, and the port C output enable follows each nibble separately.
- R8: Port B in handshake mode claims C bits 2:0. Port A in handshake mode claims C bits 5:3 when it is an input, and C bits 7, 6 and 3 when it is an output. Claimed bits are flagged in `pc_claim` and have output enable 0.
- R9: A read returns, bit by bit, the output latch where that bit is driven and the pin value sampled at the read edge where it is not.
- R10: A read of the control address returns 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Port / control select |
| wdata | input | 8 | Write data from host |
| rdata | output | 8 | Registered read data to host |
| pa_in | input | 8 | Port A pin values |
| pb_in | input | 8 | Port B pin values |
| pc_in | input | 8 | Port C pin values |
| pa_out | output | 8 | Port A output latch |
| pb_out | output | 8 | Port B output latch |
| pc_out | output | 8 | Port C output latch |
| pa_oe | output | 8 | Port A per-bit drive enable |
| pb_oe | output | 8 | Port B per-bit drive enable |
| pc_oe | output | 8 | Port C per-bit drive enable |
| pc_claim | output | 8 | Port C bits taken by a handshake |

## Verification
The configuration word is tried with several patterns:
- all outputs;
- all inputs;
- each C nibble alone as input;
- port A in handshake mode as input and as output, with port B in handshake mode too.

Together these show whether the field decode is correct and whether the two nibbles are independent. Single-bit words set a bit, set a second bit and then clear the first, against a known latch value, which exposes an off-by-one index or a write that spills into other bits. Reads are made with mixed directions on port C, so a mux that works per port instead of per bit gives a visibly wrong byte. Strobes with the chip select high check that the bus is gated.

// File: rtl/tpio_pkg.sv
package tpio_pkg;
  localparam int PORT_W = 8;
  localparam int IDX_W  = $clog2(PORT_W);

  typedef enum logic [1:0] {
    SEL_A    = 2'b00,
    SEL_B    = 2'b01,
    SEL_C    = 2'b10,
    SEL_CTRL = 2'b11
  } sel_e;

  // bit order matches configuration word bits 6:0
  typedef struct packed {
    logic [1:0] a_mode;
    logic       a_in;
    logic       cu_in;
    logic       b_mode;
    logic       b_in;
    logic       cl_in;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{a_mode: 2'b00, a_in: 1'b1, cu_in: 1'b1,
                                 b_mode: 1'b0, b_in: 1'b1, cl_in: 1'b1};
endpackage

// File: rtl/tpio_cfg_regs.sv
module tpio_cfg_regs
  import tpio_pkg::*;
#(
  parameter int W  = PORT_W,
  localparam int IW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  sel_e         sel,
  input  logic [W-1:0] wdata,
  output cfg_t         cfg_q,
  output logic [W-1:0] pa_q,
  output logic [W-1:0] pb_q,
  output logic [W-1:0] pc_q
);
  logic ctrl_wr, mode_wr, bit_wr;
  logic [IW-1:0] bit_idx;

  assign ctrl_wr = wr_en && (sel == SEL_CTRL);
  assign mode_wr = ctrl_wr && wdata[W-1];
  assign bit_wr  = ctrl_wr && !wdata[W-1];
  assign bit_idx = wdata[IW:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= CFG_RESET;
      pa_q  <= '0;
      pb_q  <= '0;
      pc_q  <= '0;
    end else if (mode_wr) begin
      cfg_q <= cfg_t'(wdata[6:0]);
      pa_q  <= '0;
      pb_q  <= '0;
      pc_q  <= '0;
    end else if (bit_wr) begin
      pc_q[bit_idx] <= wdata[0];
    end else if (wr_en) begin
      case (sel)
        SEL_A:   pa_q <= wdata;
        SEL_B:   pb_q <= wdata;
        SEL_C:   pc_q <= wdata;
        default: ;
      endcase
    end
  end

  // R5
  latch_clear_chk: assert property (@(posedge clk) disable iff (rst)
    mode_wr |=> (pa_q == '0 && pb_q == '0 && pc_q == '0));
  // R6
  single_bit_chk: assert property (@(posedge clk) disable iff (rst)
    bit_wr |=> ($countones(pc_q ^ $past(pc_q)) <= 1));
  // R6
  bit_keeps_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    bit_wr |=> $stable(cfg_q));
  // R3
  reset_input_chk: assert property (@(posedge clk)
    rst |=> (cfg_q.a_in && cfg_q.b_in && cfg_q.cu_in && cfg_q.cl_in));
endmodule

// File: rtl/tpio_pin_map.sv
module tpio_pin_map
  import tpio_pkg::*;
#(
  parameter int W = PORT_W,
  localparam int HALF = W / 2
) (
  input  cfg_t         cfg_q,
  output logic [W-1:0] pc_claim,
  output logic [W-1:0] pc_oe
);
  logic a_hs, b_hs;
  logic [W-1:0] dir_out;

  assign a_hs = (cfg_q.a_mode == 2'b01);
  assign b_hs = cfg_q.b_mode;

  for (genvar i = 0; i < W; i++) begin : g_dir
    if (i < HALF) begin : g_lo
      assign dir_out[i] = !cfg_q.cl_in;
    end else begin : g_hi
      assign dir_out[i] = !cfg_q.cu_in;
    end
  end

  always_comb begin
    pc_claim = '0;
    if (b_hs) pc_claim[2:0] = 3'b111;
    if (a_hs) begin
      if (cfg_q.a_in) pc_claim[5:3] = 3'b111;
      else begin
        pc_claim[3] = 1'b1;
        pc_claim[6] = 1'b1;
        pc_claim[7] = 1'b1;
      end
    end
  end

  assign pc_oe = dir_out & ~pc_claim;
endmodule

// File: rtl/tpio_read_path.sv
module tpio_read_path
  import tpio_pkg::*;
#(
  parameter int W = PORT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_en,
  input  logic         cs_n,
  input  sel_e         sel,
  input  logic [W-1:0] pa_q,
  input  logic [W-1:0] pb_q,
  input  logic [W-1:0] pc_q,
  input  logic [W-1:0] pa_oe,
  input  logic [W-1:0] pb_oe,
  input  logic [W-1:0] pc_oe,
  input  logic [W-1:0] pa_in,
  input  logic [W-1:0] pb_in,
  input  logic [W-1:0] pc_in,
  output logic [W-1:0] rdata
);
  logic [W-1:0] rd_mux;

  always_comb begin
    case (sel)
      SEL_A:   rd_mux = (pa_oe & pa_q) | (~pa_oe & pa_in);
      SEL_B:   rd_mux = (pb_oe & pb_q) | (~pb_oe & pb_in);
      SEL_C:   rd_mux = (pc_oe & pc_q) | (~pc_oe & pc_in);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R2
  deselect_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> $stable(rdata));
  // R10
  ctrl_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == SEL_CTRL) |=> (rdata == '0));
endmodule

// File: rtl/tpio_top.sv
module tpio_top
  import tpio_pkg::*;
#(
  parameter int W = PORT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cs_n,
  input  logic         rd_n,
  input  logic         wr_n,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic [W-1:0] pa_in,
  input  logic [W-1:0] pb_in,
  input  logic [W-1:0] pc_in,
  output logic [W-1:0] pa_out,
  output logic [W-1:0] pb_out,
  output logic [W-1:0] pc_out,
  output logic [W-1:0] pa_oe,
  output logic [W-1:0] pb_oe,
  output logic [W-1:0] pc_oe,
  output logic [W-1:0] pc_claim
);
  logic wr_en, rd_en;
  sel_e sel;
  cfg_t cfg_q;

  assign wr_en = !cs_n && !wr_n;
  assign rd_en = !cs_n && !rd_n;
  assign sel   = sel_e'(addr);

  tpio_cfg_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .sel(sel), .wdata(wdata),
    .cfg_q(cfg_q), .pa_q(pa_out), .pb_q(pb_out), .pc_q(pc_out)
  );

  tpio_pin_map #(.W(W)) u_map (
    .cfg_q(cfg_q), .pc_claim(pc_claim), .pc_oe(pc_oe)
  );

  assign pa_oe = {W{!cfg_q.a_in}};
  assign pb_oe = {W{!cfg_q.b_in}};

  tpio_read_path #(.W(W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .cs_n(cs_n), .sel(sel),
    .pa_q(pa_out), .pb_q(pb_out), .pc_q(pc_out),
    .pa_oe(pa_oe), .pb_oe(pb_oe), .pc_oe(pc_oe),
    .pa_in(pa_in), .pb_in(pb_in), .pc_in(pc_in), .rdata(rdata)
  );

  // R8
  claim_undriven_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_oe & pc_claim) == '0);
endmodule

// File: tb/tpio_top_test.sv
module tpio_top_test;
  logic clk = 0, rst = 1, cs_n = 1, rd_n = 1, wr_n = 1;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, pa_in = 0, pb_in = 0, pc_in = 0;
  logic [7:0] rdata, pa_out, pb_out, pc_out, pa_oe, pb_oe, pc_oe, pc_claim;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tpio_top uut (.*);

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input logic sel_n = 0);
    @(negedge clk); cs_n = sel_n; wr_n = 0; addr = a; wdata = d;
    @(negedge clk); cs_n = 1; wr_n = 1;
  endtask

  task automatic bus_rd(input logic [1:0] a, input logic sel_n = 0);
    @(negedge clk); cs_n = sel_n; rd_n = 0; addr = a;
    @(negedge clk); cs_n = 1; rd_n = 1;
  endtask

  task automatic t_reset;
    check("R3 pa_oe", pa_oe, 8'h00); check("R3 pb_oe", pb_oe, 8'h00);
    check("R3 pc_oe", pc_oe, 8'h00); check("R3 pa_out", pa_out, 8'h00);
    check("R3 rdata", rdata, 8'h00); check("R3 claim", pc_claim, 8'h00);
  endtask

  task automatic t_dirs;
    bus_wr(2'b11, 8'h80);
    check("R4 pa_oe out", pa_oe, 8'hFF); check("R4 pb_oe out", pb_oe, 8'hFF);
    check("R4 pc_oe out", pc_oe, 8'hFF);
    bus_wr(2'b11, 8'h9B);
    check("R4 pa_oe in", pa_oe, 8'h00); check("R4 pb_oe in", pb_oe, 8'h00);
    check("R4 pc_oe in", pc_oe, 8'h00);
  endtask

  task automatic t_writes;
    bus_wr(2'b11, 8'h80);
    bus_wr(2'b00, 8'h5A); bus_wr(2'b01, 8'hC3); bus_wr(2'b10, 8'h71);
    check("R1 pa_out", pa_out, 8'h5A); check("R1 pb_out", pb_out, 8'hC3);
    check("R1 pc_out", pc_out, 8'h71);
    bus_rd(2'b01); check("R9 read out B", rdata, 8'hC3);
    bus_wr(2'b11, 8'h80);
    check("R5 pa clr", pa_out, 8'h00); check("R5 pb clr", pb_out, 8'h00);
    check("R5 pc clr", pc_out, 8'h00);
  endtask

  task automatic t_select;
    bus_wr(2'b00, 8'h3C);
    bus_wr(2'b00, 8'hFF, 1'b1);
    check("R2 write ignored", pa_out, 8'h3C);
    bus_wr(2'b11, 8'h9B, 1'b1);
    check("R2 cfg ignored", pa_oe, 8'hFF);
    bus_rd(2'b00); check("R2 base read", rdata, 8'h3C);
    bus_rd(2'b01, 1'b1); check("R2 read ignored", rdata, 8'h3C);
  endtask

  task automatic t_bitset;
    bus_wr(2'b11, 8'h80);
    bus_wr(2'b11, 8'h0B); check("R6 set bit5", pc_out, 8'h20);
    bus_wr(2'b11, 8'h01); check("R6 set bit0", pc_out, 8'h21);
    bus_wr(2'b11, 8'h0A); check("R6 clr bit5", pc_out, 8'h01);
    bus_wr(2'b11, 8'h0F); check("R6 set bit7", pc_out, 8'h81);
    check("R6 dirs kept", pc_oe, 8'hFF); check("R6 pa kept", pa_oe, 8'hFF);
  endtask

  task automatic t_halves;
    bus_wr(2'b11, 8'h88); check("R7 upper in", pc_oe, 8'h0F);
    bus_wr(2'b11, 8'h81); check("R7 lower in", pc_oe, 8'hF0);
    bus_wr(2'b11, 8'h88); bus_wr(2'b10, 8'h36);
    pc_in = 8'hC9;
    bus_rd(2'b10); pc_in = 8'h00;
    check("R9 mixed C read", rdata, 8'hC6);
  endtask

  task automatic t_inputs;
    bus_wr(2'b11, 8'h9B);
    pa_in = 8'hA5; bus_rd(2'b00); pa_in = 8'h11;
    check("R9 pin A read", rdata, 8'hA5);
    @(negedge clk); check("R9 read held", rdata, 8'hA5);
    bus_rd(2'b11); check("R10 ctrl read", rdata, 8'h00);
  endtask

  task automatic t_handshake;
    bus_wr(2'b11, 8'hB4);
    check("R8 A in claim", pc_claim, 8'h3F); check("R8 A in oe", pc_oe, 8'hC0);
    bus_wr(2'b11, 8'hA0);
    check("R8 A out claim", pc_claim, 8'hC8); check("R8 A out oe", pc_oe, 8'h37);
    check("R8 A out pa_oe", pa_oe, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset; t_dirs; t_writes; t_select; t_bitset; t_halves; t_inputs; t_handshake;
    bus_wr(2'b00, 8'h77);
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    t_reset;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule